// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking two levels of translation tables in memory. The linear address is split three ways. The top ten bits select a word in a directory. The middle ten bits select a word in the page table that the directory word names. The low twelve bits are the offset inside a 4 KB page. All table reads and write-backs go through a single word-wide memory port that uses a request/acknowledge handshake.

A client offers one translation at a time with a valid/ready pair. Each translation carries the linear address and a write flag. The paging-enable input and the directory page number are sampled when the request is accepted. The walk ends in one of two ways:
- A one-cycle `done` pulse, with the result held on `phys_addr`.
- A one-cycle `fault` pulse, with the offending linear address kept in `fault_addr`.

After a successful walk, the walker sets the accessed flag in each entry where it was clear. On a write access it also sets the dirty flag in the leaf entry. Each such update is a separate memory write.

Entry format, shared by both levels:
- Bits 31:12 hold the next-level page number.
- Bit 0 is present.
- Bit 1 is writable.
- Bit 2 is user.
- Bit 3 is write-through.
- Bit 4 is cache-disable.
- Bit 5 is accessed.
- Bit 6 is dirty.

Top module: `pt_walker`

## Requirements
- R1: With paging enabled, the first memory access is a read at `{dir_base, 12'h000} + 4*lin[31:22]`.
- R2: The second read is at `{pde[31:12], 12'h000} + 4*lin[21:12]`. On success, `phys_addr = {pte[31:12], lin[11:0]}`.
- R3: With paging disabled at acceptance, `done` rises one cycle after acceptance with `phys_addr` equal to the linear address, and no memory access is made.
- R4: A directory entry with bit 0 clear ends the walk with `fault` after that single read. No write is made.
- R5: A table entry with bit 0 clear ends the walk with `fault`. No write is made.
- R6: A write request whose table entry has bit 1 clear ends with `fault` and makes no write. A read request to the same entry succeeds.
- R7: `fault_addr` is loaded with the linear address of a faulting walk. It keeps its value at all other times.
- R8: On success, a directory entry with bit 5 clear is written back with bit 5 set and no other change. If bit 5 was already set, no directory write is made.
- R9: On success, the table entry is written back with bit 5 set, and also bit 6 set for a write access, only if that changes it. A directory write-back always comes before the table write-back.
- R10: `req_ready` is low from acceptance until the cycle in which `done` or `fault` pulses. `done` and `fault` are single-cycle pulses and are never high together.
- R11: Each memory access holds `mem_req`, `mem_we` and a word-aligned `mem_addr` stable until a cycle in which `mem_ack` is high. Read data is taken in that cycle.
- R12: After reset: `req_ready` = 1, and `done`, `fault`, `mem_req`, `phys_addr` and `fault_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| paging_en | input | 1 | Translation on (1) or pass-through (0) |
| dir_base | input | 20 | Page number of the directory |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | Translation finished, one cycle |
| fault | output | 1 | Page fault, one cycle |
| phys_addr | output | 32 | Last translated physical address |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
The completion pulse of one walk and the acceptance of the next request can fall in the same cycle, because `req_ready` comes back together with `done` or `fault`. The bench issues each new request at the very sampling point where it sees the previous pulse, so every walk in the run starts on the edge where the previous one ends. This includes a pass-through walk landing directly after a multi-write walk. Each following walk is judged on its own results: its outcome, its physical or fault address, and the number, order and values of its memory accesses. Stale state carried over from the walk that just finished would show up there.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int PN_W     = VA_W - OFF_W;
    localparam int ENT_LOG2 = 2;
    localparam int DIR_LSB  = OFF_W + IDX_W;

    typedef struct packed {
        logic [PN_W-1:0] base;
        logic [4:0]      avail;
        logic            dirty;
        logic            accessed;
        logic            nocache;
        logic            wthru;
        logic            user;
        logic            writable;
        logic            present;
    } pt_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WB_DIR,
        ST_WB_TBL
    } walk_state_t;

    function automatic logic [VA_W-1:0] slot_addr(input logic [PN_W-1:0]  page,
                                                  input logic [IDX_W-1:0] idx);
        return {page, {OFF_W{1'b0}}} + VA_W'({idx, {ENT_LOG2{1'b0}}});
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PN_W-1:0] dir_page,
    input  logic [PN_W-1:0] tbl_page,
    input  logic [PN_W-1:0] frame_page,
    input  logic [VA_W-1:0] lin,
    output logic [VA_W-1:0] dir_slot,
    output logic [VA_W-1:0] tbl_slot,
    output logic [VA_W-1:0] phys
);
    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [OFF_W-1:0] offset;

    assign dir_idx  = lin[VA_W-1:DIR_LSB];
    assign tbl_idx  = lin[DIR_LSB-1:OFF_W];
    assign offset   = lin[OFF_W-1:0];

    assign dir_slot = slot_addr(dir_page, dir_idx);
    assign tbl_slot = slot_addr(tbl_page, tbl_idx);
    assign phys     = {frame_page, offset};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter bit LEAF = 1'b0
) (
    input  pt_entry_t ent,
    input  logic      wr,
    output logic      present,
    output logic      wr_fault,
    output logic      needs_wb,
    output pt_entry_t upd
);
    logic mark_dirty;

    assign mark_dirty = LEAF & wr;
    assign present    = ent.present;
    assign wr_fault   = LEAF & wr & ~ent.writable;

    always_comb begin
        upd          = ent;
        upd.accessed = 1'b1;
        if (mark_dirty) begin
            upd.dirty = 1'b1;
        end
    end

    assign needs_wb = ~ent.accessed | (mark_dirty & ~ent.dirty);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_lin,
    input  logic            req_write,
    input  logic            paging_en,
    input  logic [PN_W-1:0] dir_base,
    output logic            mem_req,
    output logic            mem_we,
    output logic [VA_W-1:0] mem_addr,
    output logic [VA_W-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [VA_W-1:0] mem_rdata,
    output logic            done,
    output logic            fault,
    output logic [VA_W-1:0] phys_addr,
    output logic [VA_W-1:0] fault_addr
);
    walk_state_t     state;
    logic [VA_W-1:0] lin_q;
    logic            we_q;
    logic [PN_W-1:0] base_q;
    pt_entry_t       pde_q, pte_q;
    logic            done_q, fault_q;
    logic [VA_W-1:0] phys_q, faddr_q;

    pt_entry_t       pde_src, pte_src, pde_upd, pte_upd;
    logic            pde_present, pde_wr_fault, pde_needs_wb;
    logic            pte_present, pte_wr_fault, pte_needs_wb;
    logic [VA_W-1:0] dir_slot, tbl_slot, walk_phys;
    logic            accept;

    // Entry under inspection: live read data in the read state, else the capture
    assign pde_src = (state == ST_RD_DIR) ? pt_entry_t'(mem_rdata) : pde_q;
    assign pte_src = (state == ST_RD_TBL) ? pt_entry_t'(mem_rdata) : pte_q;

    ptw_entry_eval #(.LEAF(1'b0)) u_dir_eval (
        .ent      (pde_src),
        .wr       (we_q),
        .present  (pde_present),
        .wr_fault (pde_wr_fault),
        .needs_wb (pde_needs_wb),
        .upd      (pde_upd)
    );

    ptw_entry_eval #(.LEAF(1'b1)) u_tbl_eval (
        .ent      (pte_src),
        .wr       (we_q),
        .present  (pte_present),
        .wr_fault (pte_wr_fault),
        .needs_wb (pte_needs_wb),
        .upd      (pte_upd)
    );

    ptw_addr_gen u_addr (
        .dir_page   (base_q),
        .tbl_page   (pde_q.base),
        .frame_page (pte_src.base),
        .lin        (lin_q),
        .dir_slot   (dir_slot),
        .tbl_slot   (tbl_slot),
        .phys       (walk_phys)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid & req_ready;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_slot;
        mem_wdata = pde_upd;
        unique case (state)
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_slot;
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_slot;
            end
            ST_WB_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_slot;
                mem_wdata = pde_upd;
            end
            ST_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_slot;
                mem_wdata = pte_upd;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lin_q   <= '0;
            we_q    <= 1'b0;
            base_q  <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            phys_q  <= '0;
            faddr_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        lin_q  <= req_lin;
                        we_q   <= req_write;
                        base_q <= dir_base;
                        if (paging_en) begin
                            state <= ST_RD_DIR;
                        end else begin
                            done_q <= 1'b1;
                            phys_q <= req_lin;
                        end
                    end
                end
                ST_RD_DIR: begin
                    if (mem_ack) begin
                        pde_q <= pde_src;
                        if (!pde_present) begin
                            fault_q <= 1'b1;
                            faddr_q <= lin_q;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_RD_TBL;
                        end
                    end
                end
                ST_RD_TBL: begin
                    if (mem_ack) begin
                        pte_q <= pte_src;
                        if (!pte_present || pte_wr_fault || pde_wr_fault) begin
                            fault_q <= 1'b1;
                            faddr_q <= lin_q;
                            state   <= ST_IDLE;
                        end else if (pde_needs_wb) begin
                            state <= ST_WB_DIR;
                        end else if (pte_needs_wb) begin
                            state <= ST_WB_TBL;
                        end else begin
                            done_q <= 1'b1;
                            phys_q <= walk_phys;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_WB_DIR: begin
                    if (mem_ack) begin
                        if (pte_needs_wb) begin
                            state <= ST_WB_TBL;
                        end else begin
                            done_q <= 1'b1;
                            phys_q <= walk_phys;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_WB_TBL: begin
                    if (mem_ack) begin
                        done_q <= 1'b1;
                        phys_q <= walk_phys;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign fault      = fault_q;
    assign phys_addr  = phys_q;
    assign fault_addr = faddr_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_lin,
    input logic        paging_en,
    input logic [19:0] dir_base,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        done,
    input logic        fault,
    input logic [31:0] phys_addr,
    input logic [31:0] fault_addr
);
    assert_dir_read_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && paging_en) |=>
            (mem_req && !mem_we &&
             mem_addr == ({$past(dir_base), 12'h000} + {20'h0, $past(req_lin[31:22]), 2'b00})));

    assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !paging_en) |=>
            (done && !mem_req && phys_addr == $past(req_lin)));

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !fault |-> $stable(fault_addr));

    assert_wb_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_align_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind pt_walker ptw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_lin    (req_lin),
    .paging_en  (paging_en),
    .dir_base   (dir_base),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .done       (done),
    .fault      (fault),
    .phys_addr  (phys_addr),
    .fault_addr (fault_addr)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        paging_en = 1'b0;
    logic [19:0] dir_base = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault;
    logic [31:0] phys_addr, fault_addr;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] mem [0:4095];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] wr_log [0:7];
    int          lat = 0;
    logic [31:0] prev_faddr = '0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .paging_en(paging_en),
        .dir_base(dir_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .phys_addr(phys_addr), .fault_addr(fault_addr)
    );

    // Memory model: random latency, one-cycle acknowledge, 16 KB aliased
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_log[wr_cnt % 8] = mem_addr;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[mem_addr[13:2]];
                    rd_cnt++;
                end
                lat = int'($urandom % 3);
            end else begin
                lat--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot(input logic [19:0] page, input logic [9:0] idx);
        return {page, 12'h000} + {20'h0, idx, 2'b00};
    endfunction

    task automatic walk(input logic [31:0] lin, input bit we, input bit pen,
                        input logic [19:0] base);
        logic [31:0] pde_a, pte_a, pde, pte, exp_pde, exp_pte, exp_phys;
        bit          exp_fault;
        int          exp_wr, exp_rd, rd0, wr0, n;
        pde_a = slot(base, lin[31:22]);
        pde   = mem[pde_a[13:2]];
        pte_a = slot(pde[31:12], lin[21:12]);
        pte   = mem[pte_a[13:2]];
        exp_pde = pde;
        exp_pte = pte;
        exp_phys = lin;
        exp_fault = 1'b0;
        exp_wr = 0;
        exp_rd = 0;
        if (pen) begin
            if (!pde[0]) begin
                exp_fault = 1'b1; exp_rd = 1;
            end else if (!pte[0] || (we && !pte[1])) begin
                exp_fault = 1'b1; exp_rd = 2;
            end else begin
                exp_rd   = 2;
                exp_phys = {pte[31:12], lin[11:0]};
                exp_pde  = pde | 32'h20;
                exp_pte  = pte | 32'h20 | (we ? 32'h40 : 32'h0);
                exp_wr   = (exp_pde != pde ? 1 : 0) + (exp_pte != pte ? 1 : 0);
            end
        end
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        req_valid = 1'b1; req_lin = lin; req_write = we; paging_en = pen; dir_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        if (pen) chk(req_ready == 1'b0, "R10 ready low while busy", 32'(req_ready), 32'h0);
        n = 0;
        while (!(done || fault) && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n < 200, "R10 walk completes", n, 0);
        chk(fault == exp_fault && done == !exp_fault, exp_fault ? "R4 R5 R6 fault outcome" :
            "R2 done outcome", {30'h0, done, fault}, {30'h0, !exp_fault, exp_fault});
        if (exp_fault) begin
            chk(fault_addr == lin, "R7 fault address", fault_addr, lin);
            prev_faddr = lin;
        end else begin
            chk(phys_addr == exp_phys, pen ? "R2 physical address" : "R3 pass-through",
                phys_addr, exp_phys);
            chk(fault_addr == prev_faddr, "R7 fault address held", fault_addr, prev_faddr);
        end
        chk(rd_cnt - rd0 == exp_rd, "R1 R4 read count", rd_cnt - rd0, exp_rd);
        chk(wr_cnt - wr0 == exp_wr, "R8 R9 write count", wr_cnt - wr0, exp_wr);
        if (pen) begin
            chk(mem[pde_a[13:2]] == exp_pde, "R8 directory entry", mem[pde_a[13:2]], exp_pde);
            chk(mem[pte_a[13:2]] == exp_pte, "R9 table entry", mem[pte_a[13:2]], exp_pte);
        end
        if (exp_wr == 2)
            chk(wr_log[wr0 % 8] == pde_a, "R9 directory write first", wr_log[wr0 % 8], pde_a);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[31:12] = 20'(1 + $urandom % 3);
            w[6] = 1'b0;
            w[0] = ($urandom % 4) != 0;
            mem[i] = w;
        end
        for (int i = 1024; i < 4096; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[0] = ($urandom % 4) != 0;
            mem[i] = w;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12 ready after reset", 32'(req_ready), 32'h1);
        chk(!done && !fault && !mem_req, "R12 strobes idle", {29'h0, done, fault, mem_req}, 32'h0);
        chk(phys_addr == 0 && fault_addr == 0, "R12 address regs", phys_addr | fault_addr, 32'h0);

        // R3 pass-through
        walk(32'hDEADBEEF, 1'b1, 1'b0, 20'h0);
        // R4 directory entry not present
        mem[5] = 32'h0000_1000;
        walk({10'd5, 10'd7, 12'h123}, 1'b0, 1'b1, 20'h0);
        // R5 table entry not present
        mem[6] = 32'h0000_1021;
        mem[1024 + 9] = 32'h1234_5000;
        walk({10'd6, 10'd9, 12'h456}, 1'b0, 1'b1, 20'h0);
        // R6 write to read-only page faults, read succeeds with no write-back
        mem[1024 + 10] = 32'hABCD_E021;
        walk({10'd6, 10'd10, 12'h789}, 1'b1, 1'b1, 20'h0);
        walk({10'd6, 10'd10, 12'h78A}, 1'b0, 1'b1, 20'h0);
        // R8 R9 both write-backs with dirty, directory first
        mem[7] = 32'h0000_2001;
        mem[2048 + 3] = 32'h5555_5003;
        walk({10'd7, 10'd3, 12'hABC}, 1'b1, 1'b1, 20'h0);
        // R1 non-zero directory page
        mem[2048 + 4] = 32'h0000_1001;
        mem[1024 + 11] = 32'h7777_7023;
        walk({10'd4, 10'd11, 12'hFFF}, 1'b0, 1'b1, 20'h2);
        // Pass-through directly after a completed walk
        walk(32'h0000_0FFC, 1'b0, 1'b0, 20'h0);

        for (int k = 0; k < 300; k++) begin
            walk($urandom, 1'($urandom % 2), ($urandom % 8) != 0, 20'h0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule